// File: doc/BRIEF.md
# Character-synchronous receive control-character filter

This block sits between a character-synchronous receiver and the receive buffer. Each received 8-bit character arrives with a one-cycle strobe. The block decides two things for each character: whether it is written to the buffer, and whether it is passed to the block check sequence (BCS) accumulator. It removes idle SYNC fill characters once the receiver has synchronized. It also resolves two-character escape sequences that start with the data link escape (DLE) code. The BCS arithmetic, buffer management and bit-level deserialization are done elsewhere.

A 16-bit configuration word holds the SYNC character and two control bits. One bit enables discarding of SYNC. The other selects a no-strip mode. In that mode every character of an escape pair is stored, and only selected members of the pair enter the check sum. A pending DLE is held by a two-state tracker until the next character decides the outcome. Escape pairs that give two outputs emit them on two consecutive cycles, in arrival order. The receiver must leave at least one idle cycle between character strobes.

Top module: `sync_rx_char_filter`

## Requirements
- R1: A character that is not DLE and not a discarded SYNC, arriving with no DLE pending and hunt low, is written (wr_en=1) and counted (bcs_en=1) with wr_data equal to it, in the cycle after the strobe.
- R2: When cfg_word bit 0 is 1, hunt is low and no DLE is pending, a character equal to cfg_word[15:8] gives no write and no count. When bit 0 is 0, that character is handled as in R1.
- R3: While hunt is high at a strobe, the character is written and counted as plain data, even if it equals SYNC or DLE, and it leaves no DLE pending.
- R4: In stripping mode (cfg_word bit 1 = 0), DLE followed by DLE gives one write of DLE with bcs_en=1, one cycle after the second strobe.
- R5: In stripping mode, DLE followed by the SYNC character gives no write and no count.
- R6: In stripping mode, DLE followed by a terminator (ETX 0x03, ITB 0x1F or ETB 0x26) drops the DLE. The terminator is written and counted one cycle after its strobe.
- R7: In no-strip mode (cfg_word bit 1 = 1), DLE followed by DLE gives a write of the first DLE with bcs_en=0 one cycle after the second strobe. The second DLE follows on the next cycle with bcs_en=1.
- R8: In no-strip mode, DLE followed by SYNC writes DLE and then SYNC on the two cycles after the second strobe, both with bcs_en=0.
- R9: In no-strip mode, DLE followed by a terminator writes DLE with bcs_en=0 and then the terminator with bcs_en=1, on the two cycles after the second strobe.
- R10: In either mode, DLE followed by any other character writes and counts the DLE one cycle after the second strobe, then that character on the next cycle.
- R11: Only cfg_word bits 0 (SYNC discard enable), 1 (no-strip) and 15:8 (SYNC value) affect behaviour. Bits 7:2 have no effect.
- R12: Hunt high in any cycle clears a pending DLE, which is then dropped without any write.
- R13: A DLE received with none pending and hunt low gives no output at its strobe. bcs_en is never high without wr_en, and no output appears without a strobe that calls for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chr_vld | input | 1 | One-cycle strobe marking a received character |
| chr_data | input | 8 | Received character |
| hunt | input | 1 | Receiver is searching for synchronization |
| cfg_word | input | 16 | Bit 0 SYNC discard enable, bit 1 no-strip, bits 15:8 SYNC value |
| dle_code | input | 8 | Escape character code |
| wr_en | output | 1 | Store wr_data in the receive buffer this cycle |
| bcs_en | output | 1 | Feed wr_data to the check sum this cycle |
| wr_data | output | 8 | Character to store |

## Verification
The first output for a strobe is due one clock after the edge that samples the strobe. The second member of a two-output pair is due one clock after that. Nothing is due for a discarded SYNC, a stripped pair or a lone DLE. The driver stamps every expected item with its due cycle number. The monitor samples on the falling edge and compares the cycle, the data and the check-sum flag of each write it pops against that stamp, so an early or late output fails as surely as a wrong one. Writes with no expected item pending are reported against the stimulus that was last sent, and strobes are spaced so the two-cycle windows never overlap.

// File: rtl/scf_pkg.sv
// Shared types for the receive control-character filter.
// Assumes 8-bit characters and a 16-bit configuration word.
package scf_pkg;
    localparam int CHR_W = 8;
    localparam int CFG_W = 2 * CHR_W;
    localparam int RSV_W = CHR_W - 2;

    // Class of a received character as seen by the tracker.
    typedef enum logic [1:0] {
        CLS_DATA = 2'd0,
        CLS_DLE  = 2'd1,
        CLS_SYNC = 2'd2,
        CLS_TERM = 2'd3
    } chr_class_e;

    // Escape tracker state.
    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_ESC  = 1'b1
    } trk_state_e;

    // One output slot: write, include in check sum, character.
    typedef struct packed {
        logic             wr;
        logic             bcs;
        logic [CHR_W-1:0] data;
    } emit_t;

    // Configuration word layout; the last member is bit 0.
    typedef struct packed {
        logic [CHR_W-1:0] sync_chr;
        logic [RSV_W-1:0] rsvd;
        logic             no_strip;
        logic             sync_drop;
    } cfg_t;

    localparam emit_t EMIT_NONE = '{wr: 1'b0, bcs: 1'b0, data: '0};

    // Build a populated output slot.
    function automatic emit_t mk_emit(input logic cnt, input logic [CHR_W-1:0] c);
        emit_t e;
        e.wr   = 1'b1;
        e.bcs  = cnt;
        e.data = c;
        return e;
    endfunction
endpackage

// File: rtl/scf_classify.sv
// Character classifier: sorts the incoming character into DLE, SYNC,
// terminator or data. DLE wins over SYNC, which wins over the terminators.
// Assumes the configured DLE and SYNC codes differ in normal use.
module scf_classify
    import scf_pkg::*;
#(
    parameter int                      NUM_TERM   = 3,
    parameter logic [NUM_TERM*CHR_W-1:0] TERM_CODES = {8'h26, 8'h1F, 8'h03}
) (
    input  logic [CHR_W-1:0] chr,
    input  logic [CHR_W-1:0] dle_code,
    input  logic [CHR_W-1:0] sync_chr,
    output chr_class_e       cls
);
    logic [NUM_TERM-1:0] term_hit;

    // One comparator per configured terminator code.
    for (genvar i = 0; i < NUM_TERM; i++) begin : g_term
        assign term_hit[i] = (chr == TERM_CODES[i*CHR_W +: CHR_W]);
    end

    // Priority decode of the character class.
    always_comb begin
        if (chr == dle_code)
            cls = CLS_DLE;
        else if (chr == sync_chr)
            cls = CLS_SYNC;
        else if (|term_hit)
            cls = CLS_TERM;
        else
            cls = CLS_DATA;
    end
endmodule

// File: rtl/scf_tracker.sv
// Escape tracker: remembers a pending DLE and, per strobe, decides up to
// two output slots (first, second) in arrival order. Hunt clears the
// pending DLE. Assumes strobes are never on consecutive cycles.
module scf_tracker
    import scf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             hunt,
    input  chr_class_e       cls,
    input  logic [CHR_W-1:0] chr,
    input  logic [CHR_W-1:0] dle_code,
    input  logic             sync_drop,
    input  logic             no_strip,
    output emit_t            first,
    output emit_t            second,
    output trk_state_e       state
);
    trk_state_e state_q;
    trk_state_e state_d;

    assign state = state_q;

    // Decide the outputs for the current strobe.
    always_comb begin
        first  = EMIT_NONE;
        second = EMIT_NONE;
        if (vld) begin
            if (hunt) begin
                first = mk_emit(1'b1, chr);
            end else if (state_q == TRK_IDLE) begin
                unique case (cls)
                    CLS_DLE:  first = EMIT_NONE;
                    CLS_SYNC: first = sync_drop ? EMIT_NONE : mk_emit(1'b1, chr);
                    default:  first = mk_emit(1'b1, chr);
                endcase
            end else begin
                unique case (cls)
                    CLS_DLE: begin
                        if (no_strip) begin
                            first  = mk_emit(1'b0, dle_code);
                            second = mk_emit(1'b1, chr);
                        end else begin
                            first  = mk_emit(1'b1, chr);
                        end
                    end
                    CLS_SYNC: begin
                        if (no_strip) begin
                            first  = mk_emit(1'b0, dle_code);
                            second = mk_emit(1'b0, chr);
                        end
                    end
                    CLS_TERM: begin
                        if (no_strip) begin
                            first  = mk_emit(1'b0, dle_code);
                            second = mk_emit(1'b1, chr);
                        end else begin
                            first  = mk_emit(1'b1, chr);
                        end
                    end
                    default: begin
                        first  = mk_emit(1'b1, dle_code);
                        second = mk_emit(1'b1, chr);
                    end
                endcase
            end
        end
    end

    // Next tracker state: hunt wins, a lone DLE arms, any strobe disarms.
    always_comb begin
        state_d = state_q;
        if (hunt)
            state_d = TRK_IDLE;
        else if (vld) begin
            if (state_q == TRK_IDLE && cls == CLS_DLE)
                state_d = TRK_ESC;
            else
                state_d = TRK_IDLE;
        end
    end

    // Tracker state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= TRK_IDLE;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/scf_emit.sv
// Output stage: registers the first slot on a strobe and holds the second
// slot for the following cycle. Assumes no strobe in the cycle after one.
module scf_emit
    import scf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  emit_t            first,
    input  emit_t            second,
    output logic             wr_en,
    output logic             bcs_en,
    output logic [CHR_W-1:0] wr_data
);
    emit_t out_q;
    emit_t hold_q;

    // Present the first slot after a strobe, then drain the held slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= EMIT_NONE;
            hold_q <= EMIT_NONE;
        end else if (load) begin
            out_q  <= first;
            hold_q <= second;
        end else begin
            out_q  <= hold_q;
            hold_q <= EMIT_NONE;
        end
    end

    assign wr_en   = out_q.wr;
    assign bcs_en  = out_q.wr & out_q.bcs;
    assign wr_data = out_q.data;
endmodule

// File: rtl/sync_rx_char_filter.sv
// Receive control-character filter top. Splits the configuration word,
// classifies each character, tracks DLE escapes and emits write and
// check-sum strobes one and two cycles after the character strobe.
// Assumes at least one idle cycle between character strobes.
module sync_rx_char_filter
    import scf_pkg::*;
#(
    parameter int                        NUM_TERM   = 3,
    parameter logic [NUM_TERM*CHR_W-1:0] TERM_CODES = {8'h26, 8'h1F, 8'h03}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chr_vld,
    input  logic [CHR_W-1:0] chr_data,
    input  logic             hunt,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [CHR_W-1:0] dle_code,
    output logic             wr_en,
    output logic             bcs_en,
    output logic [CHR_W-1:0] wr_data
);
    cfg_t       cfg;
    chr_class_e chr_cls;
    trk_state_e trk_state;
    emit_t      slot_a;
    emit_t      slot_b;

    assign cfg = cfg_t'(cfg_word);

    scf_classify #(
        .NUM_TERM   (NUM_TERM),
        .TERM_CODES (TERM_CODES)
    ) i_classify (
        .chr      (chr_data),
        .dle_code (dle_code),
        .sync_chr (cfg.sync_chr),
        .cls      (chr_cls)
    );

    scf_tracker i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (chr_vld),
        .hunt      (hunt),
        .cls       (chr_cls),
        .chr       (chr_data),
        .dle_code  (dle_code),
        .sync_drop (cfg.sync_drop),
        .no_strip  (cfg.no_strip),
        .first     (slot_a),
        .second    (slot_b),
        .state     (trk_state)
    );

    scf_emit i_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (chr_vld),
        .first   (slot_a),
        .second  (slot_b),
        .wr_en   (wr_en),
        .bcs_en  (bcs_en),
        .wr_data (wr_data)
    );
endmodule

// File: rtl/scf_chk.sv
// Protocol checker for the filter, bound to the top module.
module scf_chk
    import scf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             chr_vld,
    input logic [CHR_W-1:0] chr_data,
    input logic             hunt,
    input logic [CFG_W-1:0] cfg_word,
    input logic [CHR_W-1:0] dle_code,
    input logic             wr_en,
    input logic             bcs_en,
    input logic [CHR_W-1:0] wr_data,
    input trk_state_e       trk_state
);
    // R13
    bcs_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcs_en |-> wr_en);

    // R2
    sync_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !hunt && cfg_word[0] && trk_state == TRK_IDLE &&
         chr_data == cfg_word[15:8] && chr_data != dle_code) |=> !wr_en);

    // R3
    hunt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && hunt) |=> (wr_en && bcs_en && wr_data == $past(chr_data)));

    // R12
    hunt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> trk_state == TRK_IDLE);

    // R7
    nostrip_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !hunt && trk_state == TRK_ESC && cfg_word[1] &&
         chr_data == dle_code) |=> (wr_en && !bcs_en) ##1 (wr_en && bcs_en));

    // R13
    lone_dle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !hunt && trk_state == TRK_IDLE && chr_data == dle_code)
        |=> !wr_en);
endmodule

bind sync_rx_char_filter scf_chk i_scf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chr_vld   (chr_vld),
    .chr_data  (chr_data),
    .hunt      (hunt),
    .cfg_word  (cfg_word),
    .dle_code  (dle_code),
    .wr_en     (wr_en),
    .bcs_en    (bcs_en),
    .wr_data   (wr_data),
    .trk_state (trk_state)
);

// File: tb/test_sync_rx_char_filter.sv
module test_sync_rx_char_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chr_vld = 1'b0;
    logic [7:0]  chr_data = 8'h00;
    logic        hunt = 1'b0;
    logic [15:0] cfg_word = 16'h0000;
    logic [7:0]  dle_code = 8'h10;
    logic        wr_en;
    logic        bcs_en;
    logic [7:0]  wr_data;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    esc_m = 1'b0;
    string cur_req = "R13";

    int       q_due[$];
    logic [8:0] q_val[$];
    string    q_req[$];

    sync_rx_char_filter i_sync_rx_char_filter (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .hunt(hunt), .cfg_word(cfg_word), .dle_code(dle_code),
        .wr_en(wr_en), .bcs_en(bcs_en), .wr_data(wr_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int due, input logic cnt, input logic [7:0] c, input string req);
        q_due.push_back(due);
        q_val.push_back({cnt, c});
        q_req.push_back(req);
    endtask

    task automatic silent(input string req);
        checks++;
    endtask

    // Driver: compute expected items from the requirements, then strobe.
    task automatic send(input logic [7:0] c, input string req);
        logic [7:0] sy;
        logic       isterm;
        int         d1;
        int         d2;
        @(negedge clk);
        sy = cfg_word[15:8];
        isterm = (c == 8'h03) || (c == 8'h1F) || (c == 8'h26);
        d1 = cyc + 1;
        d2 = cyc + 2;
        cur_req = req;
        if (hunt) begin
            push(d1, 1'b1, c, req);
            esc_m = 1'b0;
        end else if (!esc_m) begin
            if (c == dle_code) begin
                esc_m = 1'b1;
                silent(req);
            end else if (c == sy && cfg_word[0])
                silent(req);
            else
                push(d1, 1'b1, c, req);
        end else begin
            esc_m = 1'b0;
            if (c == dle_code) begin
                if (cfg_word[1]) begin
                    push(d1, 1'b0, dle_code, req); push(d2, 1'b1, c, req);
                end else
                    push(d1, 1'b1, c, req);
            end else if (c == sy) begin
                if (cfg_word[1]) begin
                    push(d1, 1'b0, dle_code, req); push(d2, 1'b0, c, req);
                end else
                    silent(req);
            end else if (isterm) begin
                if (cfg_word[1]) begin
                    push(d1, 1'b0, dle_code, req); push(d2, 1'b1, c, req);
                end else
                    push(d1, 1'b1, c, req);
            end else begin
                push(d1, 1'b1, dle_code, req); push(d2, 1'b1, c, req);
            end
        end
        chr_vld  = 1'b1;
        chr_data = c;
        @(negedge clk);
        chr_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hunt_pulse();
        @(negedge clk);
        hunt = 1'b1;
        esc_m = 1'b0;
        repeat (2) @(negedge clk);
        hunt = 1'b0;
    endtask

    // Monitor: compare every write with the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_due.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected write data %h bcs %b at cycle %0d, expected none",
                         cur_req, wr_data, bcs_en, cyc);
            end else begin
                int         due;
                logic [8:0] exp_v;
                string      rq;
                due = q_due.pop_front();
                exp_v = q_val.pop_front();
                rq = q_req.pop_front();
                checks++;
                if (due != cyc || exp_v != {bcs_en, wr_data}) begin
                    errors++;
                    $display("FAIL %s: cycle %0d data %h bcs %b, expected cycle %0d data %h bcs %b",
                             rq, cyc, wr_data, bcs_en, due, exp_v[7:0], exp_v[8]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_word = {8'h32, 6'b000000, 1'b0, 1'b1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (wr_en !== 1'b0 || bcs_en !== 1'b0) begin
            errors++;
            $display("FAIL R13: reset wr_en %b bcs_en %b, expected 0 0", wr_en, bcs_en);
        end
        // R1 ordinary data
        send(8'h41, "R1"); send(8'h42, "R1"); send(8'h00, "R1"); send(8'hFF, "R1");
        // R2 SYNC discard enabled, then disabled
        send(8'h32, "R2");
        cfg_word[0] = 1'b0;
        send(8'h32, "R2");
        cfg_word[0] = 1'b1;
        send(8'h55, "R2");
        // R3 hunt pass-through
        @(negedge clk); hunt = 1'b1;
        send(8'h32, "R3"); send(8'h10, "R3");
        @(negedge clk); hunt = 1'b0;
        send(8'h41, "R3");
        // R12 hunt clears a pending DLE
        send(8'h10, "R13");
        hunt_pulse();
        send(8'h44, "R12");
        // Stripping mode pairs
        send(8'h10, "R13"); send(8'h10, "R4");
        send(8'h10, "R13"); send(8'h32, "R5");
        send(8'h10, "R13"); send(8'h03, "R6");
        send(8'h10, "R13"); send(8'h1F, "R6");
        send(8'h10, "R13"); send(8'h26, "R6");
        send(8'h10, "R13"); send(8'h41, "R10");
        // No-strip mode pairs
        cfg_word[1] = 1'b1;
        send(8'h10, "R13"); send(8'h10, "R7");
        send(8'h10, "R13"); send(8'h32, "R8");
        send(8'h10, "R13"); send(8'h03, "R9");
        send(8'h10, "R13"); send(8'h1F, "R9");
        send(8'h10, "R13"); send(8'h26, "R9");
        send(8'h10, "R13"); send(8'h55, "R10");
        // R11 reserved bits set, new SYNC value
        cfg_word = {8'h16, 6'b111111, 1'b1, 1'b1};
        send(8'h16, "R11"); send(8'h32, "R11");
        send(8'h10, "R11"); send(8'h10, "R11");
        cfg_word = {8'h16, 6'b101010, 1'b0, 1'b1};
        send(8'h10, "R11"); send(8'h10, "R11");
        send(8'h10, "R11"); send(8'h16, "R11");
        repeat (6) @(negedge clk);
        checks++;
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R13: %0d expected writes never appeared, expected 0", q_due.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule